// File: doc/BRIEF.md
# Shift and Rotate Unit with Flags

A purely combinational datapath slice that applies one of seven shift or rotate operations to a 16-bit operand. It also produces the carry, overflow, sign, zero and parity flags that the operation defines. The surrounding core supplies the operand, a raw count byte, a 3-bit operation code and the current carry flag.

The core then uses a write-enable to decide whether to write the result back. Two update strobes tell it which flags to commit. Each family reduces the count differently:

- Plain rotates keep the low four bits.
- Rotates through carry take the low five bits modulo 17.
- Shifts take the low five bits.

Each family therefore has its own zero-count and width-boundary behaviour. There is no stream traffic, so the block has no valid/ready handshake. Every output follows the inputs within the same cycle.

Top module: `shift_rotate_unit`

## Requirements
- R1: The operation code selects the operation as follows: 0 rotate left, 1 rotate right, 2 rotate-through-carry left, 3 rotate-through-carry right, 4 shift left, 5 logical shift right, 6 shift left, 7 arithmetic shift right. A plain rotate turns the operand by count bits [3:0].
- R2: For a plain rotate with count bits [3:0] equal to zero, `wr_en_o` is 0 and the operand is passed through. `flag_we_o` is 1 exactly when count bit 4 is set, and the flags are then computed from the unchanged operand.
- R3: After a rotate left, carry is result bit 0 and overflow is result[0] XOR result[15]. After a rotate right, carry is result[15] and overflow is result[15] XOR result[14].
- R4: Rotate-through-carry reduces the count to (count mod 32) mod 17 and rotates the 17-bit word {carry_i, operand}. A reduced count of zero gives `wr_en_o` = 0 and `flag_we_o` = 0.
- R5: Rotate-through-carry left gives carry = operand bit (16 − n) and overflow = carry XOR result[15]. Rotate-through-carry right gives carry = operand bit (n − 1) and overflow = result[15] XOR result[14].
- R6: Shifts use count mod 32. A zero reduced count drives all three enables low. Whenever `wr_en_o` is 1, `flag_we_o` is also 1.
- R7: Shift left by n from 1 to 16 gives carry = operand bit (16 − n) and overflow = carry XOR result[15]. Shift left by n above 16 gives a zero result, with carry and overflow both 0.
- R8: Logical shift right fills with zeros. Carry is operand bit (n − 1), or 0 beyond bit 15. Overflow is the original bit 15 when n = 1, and 0 otherwise.
- R9: Arithmetic shift right copies the sign bit into the vacated positions. Carry is bit (n − 1) of the sign-extended operand. Overflow is always 0.
- R10: When a shift writes, `szp_we_o` is 1 and the flags come from the result: sign = result[15], zero = (result == 0), parity = 1 when result[7:0] has an even number of ones. Rotates never assert `szp_we_o`.
- R11: When an enable is low, its outputs take fixed values. With `wr_en_o` low, `result_o` equals `operand_i`. With `flag_we_o` low, `carry_o` equals `carry_i` and `ovf_o` is 0. With `szp_we_o` low, sign, zero and parity are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | W (16) | Value to shift or rotate |
| count_i | input | CNT_W (8) | Raw count before any reduction |
| op_i | input | 3 | Operation code |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | W (16) | Shifted or rotated value |
| wr_en_o | output | 1 | Result must be written back |
| flag_we_o | output | 1 | Carry and overflow must be committed |
| carry_o | output | 1 | New carry flag |
| ovf_o | output | 1 | New overflow flag |
| szp_we_o | output | 1 | Sign, zero and parity must be committed |
| sign_o | output | 1 | New sign flag |
| zero_o | output | 1 | New zero flag |
| parity_o | output | 1 | New parity flag (even parity of low byte) |

## Verification
The bench builds the unit at its default width of 16 with an 8-bit count. At that size, every count value from 0 to 255 can be applied to every operation code with both carry-in values. This covers the discarded upper count bits, the modulo-17 wrap at counts 17 and 34-style aliases, the rotate-by-16 case with bit 4 set, and shift counts of 16, 17 and 31. The operands are a dozen patterns chosen to expose carry, sign fill, parity and the overflow rules.

// File: rtl/shift_rotate_pkg.sv
package shift_rotate_pkg;

  typedef enum logic [2:0] {
    OP_ROTL  = 3'd0,
    OP_ROTR  = 3'd1,
    OP_RCYL  = 3'd2,
    OP_RCYR  = 3'd3,
    OP_SHL   = 3'd4,
    OP_SHRL  = 3'd5,
    OP_SHL2  = 3'd6,
    OP_SHRA  = 3'd7
  } sr_op_e;

  typedef struct packed {
    logic wr;
    logic fwe;
    logic cf;
    logic of;
  } sr_ctl_t;

endpackage

// File: rtl/sru_rotate.sv
module sru_rotate
  import shift_rotate_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]         opnd,
  input  logic [$clog2(W):0]   cnt,
  input  logic                 dir_right,
  output logic [W-1:0]         res,
  output sr_ctl_t              ctl
);
  localparam int LW = $clog2(W);

  logic [LW-1:0]  amt;
  logic [2*W-1:0] dbl, to_left, to_right;

  assign amt      = cnt[LW-1:0];
  assign dbl      = {opnd, opnd};
  assign to_left  = dbl << amt;
  assign to_right = dbl >> amt;

  always_comb begin
    res     = dir_right ? to_right[W-1:0] : to_left[2*W-1:W];
    ctl.wr  = |amt;
    ctl.fwe = (|amt) | cnt[LW];
    if (dir_right) begin
      ctl.cf = res[W-1];
      ctl.of = res[W-1] ^ res[W-2];
    end else begin
      ctl.cf = res[0];
      ctl.of = res[0] ^ res[W-1];
    end
  end
endmodule

// File: rtl/sru_rotc.sv
module sru_rotc
  import shift_rotate_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]         opnd,
  input  logic [$clog2(W):0]   cnt,
  input  logic                 cin,
  input  logic                 dir_right,
  output logic [W-1:0]         res,
  output sr_ctl_t              ctl
);
  localparam int LW = $clog2(W);
  localparam int VW = W + 1;

  logic [31:0]     cnt_w;
  logic [LW:0]     red;
  logic [VW-1:0]   word;
  logic [2*VW-1:0] dbl, to_left, to_right;
  logic [VW-1:0]   rot;

  assign cnt_w    = 32'(cnt);
  assign red      = (LW+1)'(cnt_w % 32'(VW));
  assign word     = {cin, opnd};
  assign dbl      = {word, word};
  assign to_left  = dbl << red;
  assign to_right = dbl >> red;
  assign rot      = dir_right ? to_right[VW-1:0] : to_left[2*VW-1:VW];

  always_comb begin
    res     = rot[W-1:0];
    ctl.wr  = |red;
    ctl.fwe = |red;
    ctl.cf  = rot[W];
    ctl.of  = dir_right ? (res[W-1] ^ res[W-2]) : (rot[W] ^ res[W-1]);
  end
endmodule

// File: rtl/sru_shift.sv
module sru_shift
  import shift_rotate_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]         opnd,
  input  logic [$clog2(W):0]   cnt,
  input  logic [1:0]           kind,   // 0 left, 1 logical right, 2 arithmetic right
  output logic [W-1:0]         res,
  output sr_ctl_t              ctl
);
  logic [2*W-1:0]        wide_l, wide_r;
  logic signed [2*W-1:0] wide_a;

  assign wide_l = {{W{1'b0}}, opnd} << cnt;
  assign wide_r = {opnd, {W{1'b0}}} >> cnt;
  assign wide_a = $signed({opnd, {W{1'b0}}}) >>> cnt;

  always_comb begin
    ctl.wr  = |cnt;
    ctl.fwe = |cnt;
    case (kind)
      2'd1: begin
        res    = wide_r[2*W-1:W];
        ctl.cf = wide_r[W-1];
        ctl.of = res[W-1] ^ res[W-2];
      end
      2'd2: begin
        res    = wide_a[2*W-1:W];
        ctl.cf = wide_a[W-1];
        ctl.of = 1'b0;
      end
      default: begin
        if (32'(cnt) > W) begin
          res    = '0;
          ctl.cf = 1'b0;
        end else begin
          res    = wide_l[W-1:0];
          ctl.cf = wide_l[W];
        end
        ctl.of = ctl.cf ^ res[W-1];
      end
    endcase
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shift_rotate_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input  logic [W-1:0]     operand_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [2:0]       op_i,
  input  logic             carry_i,
  output logic [W-1:0]     result_o,
  output logic             wr_en_o,
  output logic             flag_we_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             szp_we_o,
  output logic             sign_o,
  output logic             zero_o,
  output logic             parity_o
);
  localparam int LW = $clog2(W);

  sr_op_e      op;
  logic [LW:0] cnt_m;
  logic [W-1:0] res_rot, res_rc, res_sh, res_sel;
  sr_ctl_t      ctl_rot, ctl_rc, ctl_sh, ctl_sel;
  logic [1:0]   sh_kind;
  logic         is_shift;

  assign op       = sr_op_e'(op_i);
  assign cnt_m    = count_i[LW:0];
  assign is_shift = op_i[2];
  assign sh_kind  = (op == OP_SHRL) ? 2'd1 : (op == OP_SHRA) ? 2'd2 : 2'd0;

  sru_rotate #(.W(W)) rot_i (
    .opnd(operand_i), .cnt(cnt_m), .dir_right(op_i[0]),
    .res(res_rot), .ctl(ctl_rot)
  );

  sru_rotc #(.W(W)) rotc_i (
    .opnd(operand_i), .cnt(cnt_m), .cin(carry_i), .dir_right(op_i[0]),
    .res(res_rc), .ctl(ctl_rc)
  );

  sru_shift #(.W(W)) shift_i (
    .opnd(operand_i), .cnt(cnt_m), .kind(sh_kind),
    .res(res_sh), .ctl(ctl_sh)
  );

  always_comb begin
    unique case (op)
      OP_ROTL, OP_ROTR: begin res_sel = res_rot; ctl_sel = ctl_rot; end
      OP_RCYL, OP_RCYR: begin res_sel = res_rc;  ctl_sel = ctl_rc;  end
      default:          begin res_sel = res_sh;  ctl_sel = ctl_sh;  end
    endcase
  end

  always_comb begin
    wr_en_o   = ctl_sel.wr;
    flag_we_o = ctl_sel.fwe;
    result_o  = ctl_sel.wr ? res_sel : operand_i;
    carry_o   = ctl_sel.fwe ? ctl_sel.cf : carry_i;
    ovf_o     = ctl_sel.fwe ? ctl_sel.of : 1'b0;
    szp_we_o  = is_shift & ctl_sel.wr;
    sign_o    = szp_we_o & res_sel[W-1];
    zero_o    = szp_we_o & (res_sel == '0);
    parity_o  = szp_we_o & ~(^res_sel[7:0]);
  end
endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk #(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input logic [W-1:0]     operand_i,
  input logic [CNT_W-1:0] count_i,
  input logic [2:0]       op_i,
  input logic             carry_i,
  input logic [W-1:0]     result_o,
  input logic             wr_en_o,
  input logic             flag_we_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             szp_we_o
);
  localparam int LW = $clog2(W);

  always_comb begin
    // R11
    idle_passthru_chk: assert (wr_en_o || result_o == operand_i);
    // R10
    rot_no_szp_chk: assert (op_i[2] || !szp_we_o);
    // R9
    sar_no_ovf_chk: assert (!(op_i == 3'd7 && flag_we_o) || !ovf_o);
    // R3
    rol_carry_chk: assert (!(op_i == 3'd0 && flag_we_o) || carry_o == result_o[0]);
    // R6
    write_has_flags_chk: assert (!wr_en_o || flag_we_o);
    // R7
    shl_far_zero_chk: assert (!((op_i == 3'd4 || op_i == 3'd6) && 32'(count_i[LW:0]) > W)
                              || (result_o == '0 && !carry_o && !ovf_o));
    // R11
    keep_carry_chk: assert (flag_we_o || carry_o == carry_i);
  end
endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(.W(W), .CNT_W(CNT_W)) chk_i (
  .operand_i(operand_i), .count_i(count_i), .op_i(op_i), .carry_i(carry_i),
  .result_o(result_o), .wr_en_o(wr_en_o), .flag_we_o(flag_we_o),
  .carry_o(carry_o), .ovf_o(ovf_o), .szp_we_o(szp_we_o)
);

// File: tb/shift_rotate_unit_tb_top.sv
module shift_rotate_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] operand_i = '0;
  logic [7:0]   count_i   = '0;
  logic [2:0]   op_i      = '0;
  logic         carry_i   = 1'b0;
  logic [W-1:0] result_o;
  logic wr_en_o, flag_we_o, carry_o, ovf_o, szp_we_o, sign_o, zero_o, parity_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  shift_rotate_unit dut_i (
    .operand_i(operand_i), .count_i(count_i), .op_i(op_i), .carry_i(carry_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .flag_we_o(flag_we_o),
    .carry_o(carry_o), .ovf_o(ovf_o), .szp_we_o(szp_we_o),
    .sign_o(sign_o), .zero_o(zero_o), .parity_o(parity_o)
  );

  function automatic logic [15:0] pick_operand(int idx);
    case (idx)
      0: return 16'h0000;  1: return 16'hFFFF;  2: return 16'h8000;
      3: return 16'h0001;  4: return 16'h8001;  5: return 16'h4000;
      6: return 16'hA5C3;  7: return 16'h5A3C;  8: return 16'h7FFF;
      9: return 16'hC000;  10: return 16'h1234; default: return 16'hF00F;
    endcase
  endfunction

  // packed {wr, res[15:0], fwe, cf, of, szpwe, s, z, p}
  function automatic logic [23:0] model(logic [2:0] op, logic [7:0] cnt,
                                        logic [15:0] v, logic cin);
    logic [15:0] r = v;
    logic c = cin, o = 1'b0, wr = 1'b0, fwe = 1'b0, szw = 1'b0;
    logic s = 1'b0, z = 1'b0, p = 1'b0, nc;
    int a;
    case (op)
      3'd0, 3'd1: begin
        a = int'(cnt) % 16;
        for (int k = 0; k < a; k++)
          r = (op == 3'd0) ? {r[14:0], r[15]} : {r[0], r[15:1]};
        wr  = (a != 0);
        fwe = (a != 0) || cnt[4];
        if (fwe) begin
          if (op == 3'd0) begin c = r[0];  o = r[0] ^ r[15]; end
          else            begin c = r[15]; o = r[15] ^ r[14]; end
        end
      end
      3'd2, 3'd3: begin
        a = (int'(cnt) % 32) % 17;
        for (int k = 0; k < a; k++) begin
          if (op == 3'd2) begin nc = r[15]; r = {r[14:0], c}; end
          else            begin nc = r[0];  r = {c, r[15:1]}; end
          c = nc;
        end
        wr = (a != 0); fwe = wr;
        if (fwe) o = (op == 3'd2) ? (c ^ r[15]) : (r[15] ^ r[14]);
      end
      default: begin
        a = int'(cnt) % 32;
        for (int k = 0; k < a; k++) begin
          if (op == 3'd5)      begin c = r[0];  r = {1'b0, r[15:1]}; end
          else if (op == 3'd7) begin c = r[0];  r = {r[15], r[15:1]}; end
          else                 begin c = r[15]; r = {r[14:0], 1'b0}; end
        end
        wr = (a != 0); fwe = wr; szw = wr;
        if (!wr) c = cin;
        else begin
          if (op == 3'd5)      o = (a == 1) ? v[15] : 1'b0;
          else if (op == 3'd7) o = 1'b0;
          else                 o = c ^ r[15];
          s = r[15]; z = (r == 16'h0000); p = ~(^r[7:0]);
        end
      end
    endcase
    return {wr, r, fwe, c, o, szw, s, z, p};
  endfunction

  function automatic string req_of(logic [2:0] op, logic [7:0] cnt);
    case (op)
      3'd0, 3'd1: return (cnt[3:0] == 4'd0) ? "R2" : "R1 R3";
      3'd2, 3'd3: return ((int'(cnt) % 32) % 17 == 0) ? "R4 R11" : "R4 R5";
      3'd5:       return (cnt[4:0] == 5'd0) ? "R6 R11" : "R8 R10";
      3'd7:       return (cnt[4:0] == 5'd0) ? "R6 R11" : "R9 R10";
      default:    return (cnt[4:0] == 5'd0) ? "R6 R11" : "R7 R10";
    endcase
  endfunction

  task automatic apply_and_check(logic [2:0] op, logic [7:0] cnt, logic [15:0] v,
                                 logic cin, string tag);
    logic [23:0] exp, act;
    @(negedge clk);
    op_i = op; count_i = cnt; operand_i = v; carry_i = cin;
    #(CLK_PERIOD/4);
    exp = model(op, cnt, v, cin);
    act = {wr_en_o, result_o, flag_we_o, carry_o, ovf_o, szp_we_o, sign_o, zero_o, parity_o};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d cnt=%0d opnd=%h cin=%0b actual=%h expected=%h",
               tag, op, cnt, v, cin, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    // R11: idle state with all inputs zero
    apply_and_check(3'd0, 8'd0, 16'h0000, 1'b0, "R11");
    // R2: rotate by 16 with bit 4 set keeps operand, refreshes flags
    apply_and_check(3'd1, 8'd16, 16'h4000, 1'b0, "R2");
    // R7: shift left by 17 and by 16
    apply_and_check(3'd4, 8'd17, 16'hFFFF, 1'b1, "R7");
    apply_and_check(3'd6, 8'd16, 16'h0001, 1'b0, "R7");
    // R4: count 17 reduces to zero for rotate through carry
    apply_and_check(3'd2, 8'd17, 16'h1234, 1'b1, "R4");
    for (int op = 0; op < 8; op++)
      for (int cnt = 0; cnt < 256; cnt++)
        for (int idx = 0; idx < 12; idx++)
          for (int cin = 0; cin < 2; cin++)
            apply_and_check(3'(op), 8'(cnt), pick_operand(idx), 1'(cin),
                            req_of(3'(op), 8'(cnt)));
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule